// File: doc/BRIEF.md
# Memory-Mapped Flash Read Prefetch Buffer

This block answers read-only, memory-mapped bus reads aimed at external serial flash from a single line buffer. The incoming address is decoded against four flash bank windows placed end to end above a programmable map base. Each window ends at its own programmable top address. A read that falls inside the buffered line is answered in the same cycle. A read that falls outside it discards the line. The block then asks an external sequence engine to run a preselected read command sequence, and that sequence streams the new line back one byte at a time.

The sequence request carries four things: the sequence number, the flash-relative start address, the byte count and the bank. The bank is given as a bus select and a chip select, where bank index = bus_sel*2 + cs. Software invalidates the buffer by raising both soft-reset inputs together. This is done, for example, after a program or erase has changed the flash contents.

Back-pressure rules: the bus master holds `rd_valid` and a stable `rd_addr` until it sees `rd_ready`. The word on `rd_data` is taken in the cycle where both are high. The sequence engine holds `fill_valid` and `fill_data` until it sees `fill_ready`. A byte is taken in the cycle where both are high.

Top module: `xip_prefetch_buf`

## Requirements
- R1: Bank i (0..3) is selected when lo_i <= rd_addr < top_i, where lo_0 = `cfg_map_base` and lo_i = top_(i-1). `cfg_bank_top` holds top_i in bits [32*i+31:32*i]. The lowest matching index wins. An address equal to a top belongs to the next bank.
- R2: A read that matches no bank gets `rd_ready` in the same cycle as `rd_valid`, returns `rd_data` = 0, and starts no refill.
- R3: A read inside the valid line whose word has arrived gets `rd_ready` in the same cycle. The data is little-endian: the byte at the word-aligned address sits in bits [7:0], and that byte is the flash byte at (word address - bank lo). No refill starts.
- R4: A mapped read that misses while no refill is running raises `seq_req` one cycle later. At the same time the block drives `seq_id` = `cfg_seq_id`, `seq_addr` = line tag - bank lo, `seq_bus_sel` = bank index bit 1 and `seq_cs` = bank index bit 0. `seq_req` and the request fields then hold until `seq_done`.
- R5: Line length L is `cfg_fill_bytes` rounded up to a multiple of 4. A value of 0, or a rounded value above BUF_BYTES (64), gives L = BUF_BYTES. `seq_len` = L. The tag is the miss address aligned down to BUF_BYTES. If the requested word would end beyond tag + L, the tag is instead the word-aligned miss address.
- R6: While a refill runs, a read inside the line keeps `rd_ready` low until all 4 bytes of its word have been accepted on the fill stream.
- R7: `fill_ready` is high only while a refill runs and fewer than L bytes have been accepted. Bytes fill the line in order from the tag.
- R8: `seq_done` ends the refill. The line length becomes the number of bytes accepted, so addresses beyond it miss again. `busy` and `seq_req` are low in the following cycle.
- R9: A miss discards the previous line, so a later read of the old line misses and refills.
- R10: `srst_bus` and `srst_flash` high in the same cycle invalidate the line and stop any refill. Either one alone has no effect.
- R11: `busy` is high from the cycle after a miss starts a refill until the cycle after `seq_done`.
- R12: After reset, `seq_req`, `busy` and `fill_ready` are low and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Bus read request valid |
| rd_addr | input | 32 | Bus read byte address |
| rd_ready | output | 1 | Read accepted, data valid this cycle |
| rd_data | output | 32 | Read word, little-endian |
| cfg_map_base | input | 32 | Lower bound of bank 0 window |
| cfg_bank_top | input | 128 | Exclusive top address of banks 0..3, 32 bits each |
| cfg_seq_id | input | 4 | Sequence number used for refills |
| cfg_fill_bytes | input | 8 | Requested line fill size in bytes |
| srst_bus | input | 1 | Bus-side soft reset |
| srst_flash | input | 1 | Flash-side soft reset |
| seq_req | output | 1 | Refill sequence request, held until done |
| seq_id | output | 4 | Sequence number of the request |
| seq_addr | output | 32 | Flash-relative start address of the refill |
| seq_len | output | 7 | Refill byte count |
| seq_bus_sel | output | 1 | Flash bus select of the bank |
| seq_cs | output | 1 | Chip select of the bank |
| seq_done | input | 1 | Sequence engine finished |
| fill_valid | input | 1 | Refill byte valid |
| fill_data | input | 8 | Refill byte |
| fill_ready | output | 1 | Refill byte accepted when valid |
| busy | output | 1 | Bus-side flash access in progress |

## Verification
The scoreboard issues read sequences of several kinds, each checked against a flash content model. There are cold misses in each bank, hits on words already streamed, and hits on words still to come. Reads are placed on both sides of each window top, and some fall outside every window. Some reads hit the old line after a new miss has replaced it. The address pairs at the window tops separate an inclusive comparison from an exclusive one. Reads at different line offsets with short fill sizes separate base-aligned tags from word-aligned fallback tags. A fill that the engine ends early separates a line whose length comes from the bytes accepted from one that assumes the full length. Pulsing one soft-reset input and then both separates a proper invalidation from one that either input alone would trigger.

// File: rtl/xpb_pkg.sv
`timescale 1ns/1ps
package xpb_pkg;
  localparam int NBANK    = 4;   // bank index = {bus_sel, cs}
  localparam int BANK_W   = $clog2(NBANK);
  localparam int SEQ_W    = 4;
  localparam int FILLCF_W = 8;
  localparam int WORD_B   = 4;

  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_FILL = 1'b1
  } line_state_e;
endpackage

// File: rtl/xpb_bank_dec.sv
`timescale 1ns/1ps
module xpb_bank_dec
  import xpb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]            addr,
  input  logic [AW-1:0]            map_base,
  input  logic [NBANK-1:0][AW-1:0] tops,
  output logic                     hit,
  output logic [BANK_W-1:0]        idx,
  output logic [AW-1:0]            base
);
  logic [AW-1:0]    lo_w [NBANK];
  logic [NBANK-1:0] match;

  for (genvar i = 0; i < NBANK; i++) begin : g_win
    if (i == 0) begin : g_first
      assign lo_w[i] = map_base;
    end else begin : g_next
      assign lo_w[i] = tops[i-1];
    end
    assign match[i] = (addr >= lo_w[i]) && (addr < tops[i]);
  end

  // lowest matching window wins
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    base = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        idx  = BANK_W'(i);
        base = lo_w[i];
      end
    end
  end
endmodule

// File: rtl/xpb_line_store.sv
`timescale 1ns/1ps
module xpb_line_store
  import xpb_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [8*WORD_B-1:0]   rd_word
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar k = 0; k < WORD_B; k++) begin : g_lane
    assign rd_word[8*k +: 8] = mem[rd_idx + IDX_W'(k)];
  end
endmodule

// File: rtl/xpb_ctrl.sv
`timescale 1ns/1ps
module xpb_ctrl
  import xpb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rd_ready,
  input  logic                 map_hit,
  input  logic [BANK_W-1:0]    bank_idx,
  input  logic [AW-1:0]        bank_base,
  input  logic [SEQ_W-1:0]     cfg_seq_id,
  input  logic [FILLCF_W-1:0]  cfg_fill_bytes,
  input  logic                 inval,
  output logic                 seq_req,
  output logic [SEQ_W-1:0]     seq_id,
  output logic [AW-1:0]        seq_addr,
  output logic [LEN_W-1:0]     seq_len,
  output logic                 seq_bus_sel,
  output logic                 seq_cs,
  input  logic                 seq_done,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [IDX_W-1:0]     rd_off,
  output logic                 busy
);
  line_state_e      state;
  logic             line_vld;
  logic [AW-1:0]    tag;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cnt;

  logic [AW-1:0]      diff;
  logic               in_line, word_ok, launch;
  logic [FILLCF_W:0]  rnd_raw, rnd;
  logic [LEN_W-1:0]   eff_len;
  logic [IDX_W-1:0]   miss_off;
  logic               fits;
  logic [AW-1:0]      new_tag;
  logic [LEN_W-1:0]   cnt_nxt;

  // position of the request relative to the held line
  assign diff    = rd_addr - tag;
  assign in_line = line_vld && (diff < AW'(len));
  assign rd_off  = {diff[IDX_W-1:2], 2'b00};
  assign word_ok = (LEN_W'(rd_off) + LEN_W'(WORD_B)) <= cnt;

  // line length from configuration
  assign rnd_raw = {1'b0, cfg_fill_bytes} + (FILLCF_W+1)'(3);
  assign rnd     = {rnd_raw[FILLCF_W:2], 2'b00};
  always_comb begin
    if (cfg_fill_bytes == '0 || int'(rnd) > BUF_BYTES) eff_len = LEN_W'(BUF_BYTES);
    else                                                eff_len = LEN_W'(rnd);
  end

  // tag of the line to be fetched
  assign miss_off = {rd_addr[IDX_W-1:2], 2'b00};
  assign fits     = (LEN_W'(miss_off) + LEN_W'(WORD_B)) <= eff_len;
  assign new_tag  = fits ? {rd_addr[AW-1:IDX_W], {IDX_W{1'b0}}}
                         : {rd_addr[AW-1:2], 2'b00};

  assign rd_ready = rd_valid && !inval && (!map_hit || (in_line && word_ok));
  assign launch   = rd_valid && !inval && map_hit && !in_line && (state == LN_IDLE);

  assign fill_ready = (state == LN_FILL) && (cnt < len) && !inval;
  assign wr_en      = fill_valid && fill_ready;
  assign wr_idx     = cnt[IDX_W-1:0];
  assign cnt_nxt    = cnt + LEN_W'(wr_en);

  assign seq_req = (state == LN_FILL);
  assign busy    = (state == LN_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= LN_IDLE;
      line_vld    <= 1'b0;
      tag         <= '0;
      len         <= '0;
      cnt         <= '0;
      seq_id      <= '0;
      seq_addr    <= '0;
      seq_len     <= '0;
      seq_bus_sel <= 1'b0;
      seq_cs      <= 1'b0;
    end else if (inval) begin
      state    <= LN_IDLE;
      line_vld <= 1'b0;
      cnt      <= '0;
    end else begin
      unique case (state)
        LN_IDLE: begin
          if (launch) begin
            state       <= LN_FILL;
            line_vld    <= 1'b1;
            tag         <= new_tag;
            len         <= eff_len;
            cnt         <= '0;
            seq_id      <= cfg_seq_id;
            seq_addr    <= new_tag - bank_base;
            seq_len     <= eff_len;
            seq_bus_sel <= bank_idx[BANK_W-1];
            seq_cs      <= bank_idx[0];
          end
        end
        LN_FILL: begin
          cnt <= cnt_nxt;
          if (seq_done) begin
            state <= LN_IDLE;
            len   <= cnt_nxt;
          end
        end
        default: state <= LN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xip_prefetch_buf.sv
`timescale 1ns/1ps
module xip_prefetch_buf
  import xpb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_valid,
  input  logic [AW-1:0]            rd_addr,
  output logic                     rd_ready,
  output logic [8*WORD_B-1:0]      rd_data,
  input  logic [AW-1:0]            cfg_map_base,
  input  logic [NBANK-1:0][AW-1:0] cfg_bank_top,
  input  logic [SEQ_W-1:0]         cfg_seq_id,
  input  logic [FILLCF_W-1:0]      cfg_fill_bytes,
  input  logic                     srst_bus,
  input  logic                     srst_flash,
  output logic                     seq_req,
  output logic [SEQ_W-1:0]         seq_id,
  output logic [AW-1:0]            seq_addr,
  output logic [LEN_W-1:0]         seq_len,
  output logic                     seq_bus_sel,
  output logic                     seq_cs,
  input  logic                     seq_done,
  input  logic                     fill_valid,
  input  logic [7:0]               fill_data,
  output logic                     fill_ready,
  output logic                     busy
);
  logic              map_hit;
  logic [BANK_W-1:0] bank_idx;
  logic [AW-1:0]     bank_base;
  logic              inval;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_off;
  logic [8*WORD_B-1:0] line_word;

  assign inval = srst_bus && srst_flash;

  xpb_bank_dec #(.AW(AW)) u_dec (
    .addr     (rd_addr),
    .map_base (cfg_map_base),
    .tops     (cfg_bank_top),
    .hit      (map_hit),
    .idx      (bank_idx),
    .base     (bank_base)
  );

  xpb_ctrl #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_valid       (rd_valid),
    .rd_addr        (rd_addr),
    .rd_ready       (rd_ready),
    .map_hit        (map_hit),
    .bank_idx       (bank_idx),
    .bank_base      (bank_base),
    .cfg_seq_id     (cfg_seq_id),
    .cfg_fill_bytes (cfg_fill_bytes),
    .inval          (inval),
    .seq_req        (seq_req),
    .seq_id         (seq_id),
    .seq_addr       (seq_addr),
    .seq_len        (seq_len),
    .seq_bus_sel    (seq_bus_sel),
    .seq_cs         (seq_cs),
    .seq_done       (seq_done),
    .fill_valid     (fill_valid),
    .fill_ready     (fill_ready),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .rd_off         (rd_off),
    .busy           (busy)
  );

  xpb_line_store #(.BUF_BYTES(BUF_BYTES)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (fill_data),
    .rd_idx  (rd_off),
    .rd_word (line_word)
  );

  assign rd_data = map_hit ? line_word : '0;
endmodule

// File: rtl/xpb_checker.sv
`timescale 1ns/1ps
module xpb_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          srst_bus,
  input logic          srst_flash,
  input logic          seq_req,
  input logic [AW-1:0] seq_addr,
  input logic          seq_done,
  input logic          fill_ready,
  input logic          busy
);
  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_valid);

  p_launch_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !busy && !(srst_bus && srst_flash)) |=> seq_req);

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !seq_done && !(srst_bus && srst_flash)) |=> seq_req);

  p_req_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && $past(seq_req)) |-> $stable(seq_addr));

  p_fill_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> busy);

  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_done) |=> (!seq_req && !busy));

  p_inval_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_bus && srst_flash) |=> (!seq_req && !fill_ready));
endmodule

bind xip_prefetch_buf xpb_checker #(.AW(AW)) u_xpb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .srst_bus   (srst_bus),
  .srst_flash (srst_flash),
  .seq_req    (seq_req),
  .seq_addr   (seq_addr),
  .seq_done   (seq_done),
  .fill_ready (fill_ready),
  .busy       (busy)
);

// File: tb/tb_xip_prefetch_buf.sv
`timescale 1ns/1ps
module tb_xip_prefetch_buf;
  localparam logic [31:0] MB   = 32'h2000_0000;
  localparam logic [31:0] SPAN = 32'h0400_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             rd_valid = 1'b0;
  logic [31:0]      rd_addr = '0;
  logic             rd_ready;
  logic [31:0]      rd_data;
  logic [3:0][31:0] cfg_bank_top;
  logic [3:0]       cfg_seq_id = 4'hA;
  logic [7:0]       cfg_fill_bytes = 8'd0;
  logic             srst_bus = 1'b0, srst_flash = 1'b0;
  logic             seq_req;
  logic [3:0]       seq_id;
  logic [31:0]      seq_addr;
  logic [6:0]       seq_len;
  logic             seq_bus_sel, seq_cs;
  logic             seq_done = 1'b0;
  logic             fill_valid = 1'b0;
  logic [7:0]       fill_data = '0;
  logic             fill_ready, busy;

  for (genvar i = 0; i < 4; i++) begin : g_top
    assign cfg_bank_top[i] = MB + SPAN * (i + 1);
  end

  xip_prefetch_buf dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .cfg_map_base(MB),
    .cfg_bank_top(cfg_bank_top), .cfg_seq_id(cfg_seq_id),
    .cfg_fill_bytes(cfg_fill_bytes), .srst_bus(srst_bus), .srst_flash(srst_flash),
    .seq_req(seq_req), .seq_id(seq_id), .seq_addr(seq_addr), .seq_len(seq_len),
    .seq_bus_sel(seq_bus_sel), .seq_cs(seq_cs), .seq_done(seq_done),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
    .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flash content model
  function automatic logic [7:0] fbyte(input logic [1:0] bank, input logic [31:0] fa);
    return fa[7:0] ^ {fa[13:8], 2'b01} ^ {bank, 6'h15};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [31:0] wa, fa;
    wa = {a[31:2], 2'b00};
    for (int b = 0; b < 4; b++) begin
      if (wa >= MB + SPAN * b && wa < MB + SPAN * (b + 1)) begin
        fa = wa - (MB + SPAN * b);
        return {fbyte(2'(b), fa + 3), fbyte(2'(b), fa + 2),
                fbyte(2'(b), fa + 1), fbyte(2'(b), fa)};
      end
    end
    return 32'h0;
  endfunction

  // sequence engine model
  int          n_refill = 0;
  int          bytes_sent = 0;
  int          short_len = 0;
  logic [31:0] r_addr;
  logic [6:0]  r_len;
  logic [3:0]  r_id;
  logic        r_bus, r_cs;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && seq_req) begin
        int n;
        bit hs;
        r_addr = seq_addr; r_len = seq_len; r_id = seq_id;
        r_bus = seq_bus_sel; r_cs = seq_cs;
        n_refill++;
        bytes_sent = 0;
        chk("R11", "busy at request", 32'(busy), 32'd1);
        n = (short_len > 0 && short_len < int'(r_len)) ? short_len : int'(r_len);
        for (int i = 0; i < n; i++) begin
          if (i % 3 == 2) @(posedge clk);
          @(posedge clk); #1;
          fill_valid = 1'b1;
          fill_data  = fbyte({r_bus, r_cs}, r_addr + 32'(i));
          do begin
            @(negedge clk); hs = fill_ready;
            @(posedge clk);
          end while (!hs);
          #1;
          bytes_sent++;
          fill_valid = 1'b0;
        end
        @(negedge clk);
        if (n == int'(r_len))
          chk("R7", "fill_ready after full line", 32'(fill_ready), 32'd0);
        @(posedge clk); #1 seq_done = 1'b1;
        @(posedge clk); #1 seq_done = 1'b0;
        chk("R8", "seq_req after done", 32'(seq_req), 32'd0);
        chk("R8", "busy after done", 32'(busy), 32'd0);
      end
    end
  end

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          hs_bytes = 0;

  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      hs_bytes = bytes_sent;
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 unexpected read response actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "read data", rd_data, e);
      end
    end
  end

  task automatic rd(input logic [31:0] a, input string req);
    bit hs;
    exp_q.push_back(exp_word(a));
    tag_q.push_back(req);
    @(posedge clk); #1;
    rd_valid = 1'b1; rd_addr = a;
    do begin
      @(negedge clk); hs = rd_ready;
      @(posedge clk);
    end while (!hs);
    #1 rd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (seq_req);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_req(input string req, input logic [31:0] ea, input int el,
                         input bit eb, input bit ec);
    chk(req, "seq_addr", r_addr, ea);
    chk(req, "seq_len", 32'(r_len), 32'(el));
    chk(req, "seq_bus_sel", 32'(r_bus), 32'(eb));
    chk(req, "seq_cs", 32'(r_cs), 32'(ec));
    chk(req, "seq_id", 32'(r_id), 32'(cfg_seq_id));
  endtask

  initial begin
    #100000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base_n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "seq_req", 32'(seq_req), 32'd0);
    chk("R12", "busy", 32'(busy), 32'd0);
    chk("R12", "fill_ready", 32'(fill_ready), 32'd0);
    chk("R12", "rd_ready", 32'(rd_ready), 32'd0);

    // R2 unmapped below base
    rd(32'h1000_0000, "R2");
    chk("R2", "refills after unmapped", 32'(n_refill), 32'd0);

    // R4 R6 cold miss in bank 0, word at offset 0x24
    rd(MB + 32'h124, "R4");
    chk("R4", "refill count", 32'(n_refill), 32'd1);
    chk_req("R4", 32'h100, 64, 1'b0, 1'b0);
    n_chk++;
    if (hs_bytes < 40) begin
      n_bad++;
      $display("FAIL R6 bytes before response actual=%0d expected>=40", hs_bytes);
    end

    // R3 hits: one still streaming, one already present
    rd(MB + 32'h13C, "R3");
    rd(MB + 32'h100, "R3");
    chk("R3", "refills after hits", 32'(n_refill), 32'd1);

    // R1 R4 bank 3
    rd(MB + 3 * SPAN + 32'h2_0008, "R1");
    chk_req("R1", 32'h2_0000, 64, 1'b1, 1'b1);

    // R9 old line now misses
    wait_idle();
    base_n = n_refill;
    rd(MB + 32'h104, "R9");
    chk("R9", "refill of replaced line", 32'(n_refill), 32'(base_n + 1));

    // R1 window edges
    rd(MB + 2 * SPAN, "R1");
    chk_req("R1", 32'h0, 64, 1'b1, 1'b0);
    rd(MB + 2 * SPAN - 4, "R1");
    chk_req("R1", SPAN - 64, 64, 1'b0, 1'b1);
    wait_idle();
    base_n = n_refill;
    rd(MB + 4 * SPAN, "R2");
    chk("R2", "refills at top of last bank", 32'(n_refill), 32'(base_n));

    // R5 short line with word-aligned fallback tag
    cfg_fill_bytes = 8'd13;
    rd(MB + 32'h1228, "R5");
    chk_req("R5", 32'h1228, 16, 1'b0, 1'b0);
    wait_idle();
    base_n = n_refill;
    rd(MB + 32'h1234, "R5");
    chk("R5", "hit in short line", 32'(n_refill), 32'(base_n));
    rd(MB + 32'h1200, "R5");
    chk_req("R5", 32'h1200, 16, 1'b0, 1'b0);

    // R5 oversize setting clamps to buffer size
    cfg_fill_bytes = 8'd200;
    rd(MB + 32'h1300, "R5");
    chk_req("R5", 32'h1300, 64, 1'b0, 1'b0);

    // R10 soft reset
    wait_idle();
    base_n = n_refill;
    @(posedge clk); #1 srst_bus = 1'b1;
    repeat (2) @(posedge clk); #1 srst_bus = 1'b0;
    @(posedge clk); #1 srst_flash = 1'b1;
    repeat (2) @(posedge clk); #1 srst_flash = 1'b0;
    rd(MB + 32'h1308, "R10");
    chk("R10", "single reset input keeps line", 32'(n_refill), 32'(base_n));
    @(posedge clk); #1 begin srst_bus = 1'b1; srst_flash = 1'b1; end
    repeat (2) @(posedge clk); #1 begin srst_bus = 1'b0; srst_flash = 1'b0; end
    rd(MB + 32'h1308, "R10");
    chk("R10", "both inputs invalidate", 32'(n_refill), 32'(base_n + 1));

    // R8 early done truncates the line
    wait_idle();
    cfg_fill_bytes = 8'd0;
    short_len = 16;
    rd(MB + 32'h1404, "R8");
    wait_idle();
    base_n = n_refill;
    rd(MB + 32'h1408, "R8");
    chk("R8", "hit inside received part", 32'(n_refill), 32'(base_n));
    short_len = 0;
    rd(MB + 32'h1420, "R8");
    chk("R8", "miss beyond received part", 32'(n_refill), 32'(base_n + 1));

    wait_idle();
    chk("R3", "scoreboard empty", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule